// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 8-bit ports, A and B, and can pass data either way. Each direction owns a holding register and a selector, so the outputs of a port carry either the live value seen on the other port or a value captured there earlier. Each port's pins are modelled as three signals: an input, an output and an output enable. The enable for the B side is active high. The enable for the A side is active low.

The two capture inputs behave as clocks. The block samples them with the system clock, and a small state machine per direction turns each low-to-high change into a single load pulse. The machine has two named states. In `EDGE_WAIT_LOW` it waits until the capture input has been seen low, moving on the transition *seen-low*. In `EDGE_ARMED` a high capture input fires a load, and the transition *rise* returns the machine to `EDGE_WAIT_LOW`.

Reset places both machines in `EDGE_WAIT_LOW` and clears both registers. One setting is illegal: both enables active while both selectors pick live data. In that setting the two ports would feed each other in a loop. The block raises an error flag and turns both sets of drivers off.

Top module: `bus_xcvr_reg`

## Requirements
- R1: While the synchronous active-high `rst` is high at a clock edge, both holding registers clear to zero. This can be seen with both selectors at 1, where `a_out` and `b_out` read 0.
- R2: A 0-to-1 change of `cap_ab` loads `a_in` into the A-to-B register at the first clock edge that samples `cap_ab` high. Holding `cap_ab` high does not load again.
- R3: A 0-to-1 change of `cap_ba` loads `b_in` into the B-to-A register at the first clock edge that samples `cap_ba` high.
- R4: `b_out` equals the A-to-B register when `sel_ab`=1, and equals `a_in` when `sel_ab`=0. The path is combinational.
- R5: `a_out` equals the B-to-A register when `sel_ba`=1, and equals `b_in` when `sel_ba`=0. The path is combinational.
- R6: When there is no loop, `b_oe` equals `en_ab` (active high) and `a_oe` equals the inverse of `en_ba_n` (active low).
- R7: `loop_err` is 1 exactly when `en_ab`=1, `en_ba_n`=0, `sel_ab`=0 and `sel_ba`=0. While it is 1, `a_oe` and `b_oe` are both 0.
- R8: A capture input that is high during reset and stays high after it causes no load. A load needs the input to be seen low and then high again.
- R9: With both ports held at 0, one rising edge on each capture input clears both registers.
- R10: While a capture input stays low, its register keeps its value, whatever its port does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 8 | Value present on port A |
| b_in | input | 8 | Value present on port B |
| cap_ab | input | 1 | Capture clock for the A-to-B register |
| cap_ba | input | 1 | Capture clock for the B-to-A register |
| sel_ab | input | 1 | 1: port B shows the stored value, 0: port B shows the live port A value |
| sel_ba | input | 1 | 1: port A shows the stored value, 0: port A shows the live port B value |
| en_ab | input | 1 | Active-high enable for the port B drivers |
| en_ba_n | input | 1 | Active-low enable for the port A drivers |
| a_out | output | 8 | Data driven toward port A |
| a_oe | output | 1 | Port A driver enable |
| b_out | output | 8 | Data driven toward port B |
| b_oe | output | 1 | Port B driver enable |
| loop_err | output | 1 | Illegal loop setting detected |

## Verification
The assertions assume that the capture inputs and data ports are stable around each system clock edge. This lets a load be compared with the port value sampled one cycle earlier. The bench therefore changes every input only at falling edges and reads the outputs shortly before the next rising edge. Capture pulses last at least one full cycle high and are followed by one full cycle low, so every rise reaches the machine while it is in its armed state. The loop setting is applied deliberately in the vector table, but only ever as a combinational input. No loaded value depends on it.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;
    typedef enum logic {
        EDGE_WAIT_LOW = 1'b0,
        EDGE_ARMED    = 1'b1
    } edge_state_t;

    localparam int DIR_AB = 0;
    localparam int DIR_BA = 1;
    localparam int N_DIR  = 2;
endpackage

// File: rtl/bus_xcvr_edge_fsm.sv
module bus_xcvr_edge_fsm
    import bus_xcvr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cap,
    output logic load
);
    edge_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= EDGE_WAIT_LOW;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EDGE_WAIT_LOW: if (!cap) state_d = EDGE_ARMED;
            EDGE_ARMED:    if (cap)  state_d = EDGE_WAIT_LOW;
            default:       state_d = EDGE_WAIT_LOW;
        endcase
    end

    always_comb begin
        load = 1'b0;
        unique case (state_q)
            EDGE_ARMED:    load = cap;
            EDGE_WAIT_LOW: load = 1'b0;
            default:       load = 1'b0;
        endcase
    end

    // a held-high capture input never fires twice in a row (R2)
    assert_single_load_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> !load);
endmodule

// File: rtl/bus_xcvr_hold_reg.sv
module bus_xcvr_hold_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end

    assert_load_captures_R3: assert property (@(posedge clk) disable iff (rst)
        load |=> (q == $past(d)));

    assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));
endmodule

// File: rtl/bus_xcvr_route.sv
module bus_xcvr_route #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic [WIDTH-1:0] q_ab,
    input  logic [WIDTH-1:0] q_ba,
    input  logic             sel_ab,
    input  logic             sel_ba,
    input  logic             en_ab,
    input  logic             en_ba_n,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe,
    output logic             loop_err
);
    logic a_req, b_req;

    always_comb begin
        a_req    = !en_ba_n;
        b_req    = en_ab;
        loop_err = a_req && b_req && !sel_ab && !sel_ba;
        b_out    = sel_ab ? q_ab : a_in;
        a_out    = sel_ba ? q_ba : b_in;
        b_oe     = b_req && !loop_err;
        a_oe     = a_req && !loop_err;
    end
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
    import bus_xcvr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             cap_ab,
    input  logic             cap_ba,
    input  logic             sel_ab,
    input  logic             sel_ba,
    input  logic             en_ab,
    input  logic             en_ba_n,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe,
    output logic             loop_err
);
    logic [N_DIR-1:0]            cap_vec;
    logic [N_DIR-1:0]            load_vec;
    logic [N_DIR-1:0][WIDTH-1:0] d_vec;
    logic [N_DIR-1:0][WIDTH-1:0] q_vec;

    assign cap_vec[DIR_AB] = cap_ab;
    assign cap_vec[DIR_BA] = cap_ba;
    assign d_vec[DIR_AB]   = a_in;
    assign d_vec[DIR_BA]   = b_in;

    for (genvar g = 0; g < N_DIR; g++) begin : g_dir
        bus_xcvr_edge_fsm u_edge (
            .clk  (clk),
            .rst  (rst),
            .cap  (cap_vec[g]),
            .load (load_vec[g])
        );
        bus_xcvr_hold_reg #(.WIDTH(WIDTH)) u_hold (
            .clk  (clk),
            .rst  (rst),
            .load (load_vec[g]),
            .d    (d_vec[g]),
            .q    (q_vec[g])
        );
    end

    bus_xcvr_route #(.WIDTH(WIDTH)) u_route (
        .a_in     (a_in),
        .b_in     (b_in),
        .q_ab     (q_vec[DIR_AB]),
        .q_ba     (q_vec[DIR_BA]),
        .sel_ab   (sel_ab),
        .sel_ba   (sel_ba),
        .en_ab    (en_ab),
        .en_ba_n  (en_ba_n),
        .a_out    (a_out),
        .a_oe     (a_oe),
        .b_out    (b_out),
        .b_oe     (b_oe),
        .loop_err (loop_err)
    );

    assert_loop_disables_R7: assert property (@(posedge clk) disable iff (rst)
        loop_err |-> (!a_oe && !b_oe));

    assert_b_enable_polarity_R6: assert property (@(posedge clk) disable iff (rst)
        b_oe |-> en_ab);

    assert_a_enable_polarity_R6: assert property (@(posedge clk) disable iff (rst)
        a_oe |-> !en_ba_n);
endmodule

// File: tb/test_bus_xcvr_reg.sv
module test_bus_xcvr_reg;
    localparam int W = 8;
    localparam int NV = 10;
    // {en_ab, en_ba_n, sel_ab, sel_ba, a_in, b_in}
    localparam logic [19:0] VEC [NV] = '{
        {4'b1100, 8'h12, 8'h34},
        {4'b1000, 8'hA5, 8'h5A},
        {4'b0000, 8'hFF, 8'h00},
        {4'b1110, 8'h0F, 8'hF0},
        {4'b0001, 8'h81, 8'h18},
        {4'b0011, 8'h77, 8'h88},
        {4'b1111, 8'h01, 8'h02},
        {4'b0100, 8'hC0, 8'h03},
        {4'b1010, 8'h55, 8'hAA},
        {4'b1001, 8'h66, 8'h99}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic cap_ab = 1'b0, cap_ba = 1'b0;
    logic sel_ab = 1'b0, sel_ba = 1'b0, en_ab = 1'b0, en_ba_n = 1'b1;
    logic [W-1:0] a_out, b_out;
    logic a_oe, b_oe, loop_err;

    int n_run = 0, n_fail = 0;
    logic [W-1:0] m_ab = '0, m_ba = '0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bus_xcvr_reg #(.WIDTH(W)) i_bus_xcvr_reg (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .cap_ab(cap_ab), .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .en_ab(en_ab), .en_ba_n(en_ba_n), .a_out(a_out), .a_oe(a_oe),
        .b_out(b_out), .b_oe(b_oe), .loop_err(loop_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
        #5;
    endtask

    // show both stored values on the outputs
    task automatic show_regs(input string req, input logic [W-1:0] eab, input logic [W-1:0] eba);
        @(negedge clk);
        sel_ab = 1'b1; sel_ba = 1'b1;
        #5;
        chk(req, {24'd0, b_out}, {24'd0, eab});
        chk(req, {24'd0, a_out}, {24'd0, eba});
    endtask

    task automatic pulse(input bit ab, input bit ba, input logic [W-1:0] av, input logic [W-1:0] bv);
        @(negedge clk);
        a_in = av; b_in = bv;
        if (ab) cap_ab = 1'b1;
        if (ba) cap_ba = 1'b1;
        @(negedge clk);
        cap_ab = 1'b0; cap_ba = 1'b0;
        @(negedge clk);
        if (ab) m_ab = av;
        if (ba) m_ba = bv;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R8: capture high through reset and after release
        cap_ab = 1'b1; cap_ba = 1'b1; a_in = 8'h5A; b_in = 8'hA5;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        show_regs("R8", 8'h00, 8'h00);
        show_regs("R1", 8'h00, 8'h00);
        cap_ab = 1'b0; cap_ba = 1'b0;
        @(negedge clk);

        pulse(1'b1, 1'b0, 8'h3C, 8'h00);
        show_regs("R2", 8'h3C, 8'h00);
        pulse(1'b0, 1'b1, 8'h00, 8'hC3);
        show_regs("R3", 8'h3C, 8'hC3);

        // vector table: selection, enables, loop flag (R4 R5 R6 R7)
        for (int i = 0; i < NV; i++) begin
            logic e_ab, e_ban, s_ab, s_ba, lp;
            @(negedge clk);
            {e_ab, e_ban, s_ab, s_ba, a_in, b_in} = VEC[i];
            en_ab = e_ab; en_ba_n = e_ban; sel_ab = s_ab; sel_ba = s_ba;
            #5;
            lp = e_ab && !e_ban && !s_ab && !s_ba;
            chk("R4", {24'd0, b_out}, {24'd0, (s_ab ? m_ab : a_in)});
            chk("R5", {24'd0, a_out}, {24'd0, (s_ba ? m_ba : b_in)});
            chk("R7", {31'd0, loop_err}, {31'd0, lp});
            chk("R6", {31'd0, b_oe}, {31'd0, (e_ab && !lp)});
            chk("R6", {31'd0, a_oe}, {31'd0, (!e_ban && !lp)});
        end
        en_ab = 1'b0; en_ba_n = 1'b1;

        // R10: ports change with captures low
        @(negedge clk); a_in = 8'hEE; b_in = 8'hDD;
        repeat (3) @(negedge clk);
        show_regs("R10", 8'h3C, 8'hC3);

        // R2: capture held high, port changes afterwards
        @(negedge clk); a_in = 8'h11; cap_ab = 1'b1;
        @(negedge clk); a_in = 8'h22;
        repeat (3) @(negedge clk);
        cap_ab = 1'b0;
        @(negedge clk);
        show_regs("R2", 8'h11, 8'hC3);

        // R9: both ports low, one edge each
        pulse(1'b1, 1'b1, 8'h00, 8'h00);
        show_regs("R9", 8'h00, 8'h00);

        // R1: mid-run reset
        pulse(1'b1, 1'b1, 8'h9C, 8'h6B);
        show_regs("R3", 8'h9C, 8'h6B);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        show_regs("R1", 8'h00, 8'h00);

        settle();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule